// File: doc/BRIEF.md
# Prescaled Two-Channel Pulse-Width Modulator

This block produces two independent pulse-width modulated outputs from one input clock. Each channel has three registers. The first holds a clock divider value and a shutdown-style bit. The second holds a high-time count and a force-high flag. The third holds a period length. A channel first divides the clock by (divider + 1). It then counts that slow tick from 0 up to the period value and wraps. The output is high at the start of every period for as many ticks as the high-time count, or for the whole period when the force-high flag is set.

Software programs the channels through a simple synchronous write port with a combinational read-back. Each channel is started and stopped by its own enable pin. Register writes land in a programmed copy. A running channel loads that copy only when a period wraps, so a change never cuts a pulse short.

Top module: `pwm_dual_ch`

## Requirements
- R1: Each channel owns a 16-byte window: channel 0 at 0x00 and channel 1 at 0x10. Inside the window, 0x0 is the control register (bits 5:0 divider, bit 6 shutdown bit), 0x4 is the duty register (bits 9:0 high-time count, bit 10 force-high flag) and 0x8 is the period register (bits 9:0). A read returns the last value written to those bits, with every other bit zero. Any other offset reads zero and ignores writes.
- R2: After reset all registers read zero and both outputs are low.
- R3: A running channel repeats with a period of (divider + 1) × (period value + 1) input clock cycles.
- R4: The output is high for (divider + 1) × (high-time count) cycles at the start of each period and low for the rest.
- R5: With the force-high flag set, the output stays high for the whole period whatever the high-time count is.
- R6: A high-time count of 0 with the flag clear gives a constant low output. A count larger than the period value + 1 gives a constant high output.
- R7: A register write made while a channel runs does not change the period in progress; it takes effect from the next period start.
- R8: When the enable pin goes low while the shutdown bit is 1, the output is low from the next clock cycle on.
- R9: When the enable pin goes low while the shutdown bit is 0, the current period completes unchanged, and then the output stays low; the output never rises while the enable pin is low.
- R10: The two channels are independent: writes to one window leave the other channel's registers and waveform unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all counting is in these cycles |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, sampled on the rising clock edge |
| addr | input | 5 | Byte address for writes and reads |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| chEnable | input | 2 | Per-channel run request, one bit per channel |
| pwmOut | output | 2 | Registered modulated outputs, one bit per channel |

## Verification
The hardest case to reach from the ports is a register write that arrives in the middle of a running period. The write must be timed to the output waveform so that its effect can be told apart from the deferred load. The stimulus waits for a rising output edge and writes a larger high-time count two cycles later. It then samples the cycles that the old count would keep low and the new count would drive high. The two stop modes need similar timing: the enable pin is dropped in the first high cycle of a period, so an early cut-off and a missing remainder of the pulse can each be seen.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int PRE_W  = 6;        // divider field width
  localparam int PV_W   = 10;       // period and high-time count width
  localparam int SD_BIT = PRE_W;    // shutdown bit follows the divider field
  localparam int FD_BIT = PV_W;     // force-high flag follows the count field
  localparam int OFS_W  = 4;        // byte offset bits inside a channel window

  localparam logic [OFS_W-1:0] OFS_CTRL = 4'h0;
  localparam logic [OFS_W-1:0] OFS_DUTY = 4'h4;
  localparam logic [OFS_W-1:0] OFS_PER  = 4'h8;

  // timing settings handed from the register bank to a channel datapath
  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [PV_W-1:0]  dc;
    logic             fd;
    logic [PV_W-1:0]  pv;
  } chTime_t;

  // per-cycle commands from control to a datapath
  typedef struct packed {
    logic runReq;   // keep running / start when idle
    logic killNow;  // stop at once and force low
  } chStrobe_t;
endpackage

// File: rtl/pwm_regbank.sv
module pwm_regbank
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wrData,
  output logic [DATA_W-1:0]             rdData,
  input  logic [NUM_CH-1:0]             chEnable,
  output chTime_t   [NUM_CH-1:0]        tim,
  output chStrobe_t [NUM_CH-1:0]        strb
);
  localparam int CH_SEL_W = ADDR_W - OFS_W;

  logic [CH_SEL_W-1:0] chSel;
  logic [OFS_W-1:0]    regSel;
  logic [NUM_CH-1:0]   sdBits;
  logic                unusedBits;

  assign chSel      = addr[ADDR_W-1:OFS_W];
  assign regSel     = addr[OFS_W-1:0];
  assign unusedBits = ^wrData[DATA_W-1:FD_BIT+1];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_reg
    logic             hit;
    logic [PRE_W-1:0] preQ;
    logic             sdQ;
    logic [PV_W-1:0]  dcQ;
    logic             fdQ;
    logic [PV_W-1:0]  pvQ;

    assign hit = wrEn && (chSel == CH_SEL_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        preQ <= '0;
        sdQ  <= 1'b0;
        dcQ  <= '0;
        fdQ  <= 1'b0;
        pvQ  <= '0;
      end else if (hit) begin
        case (regSel)
          OFS_CTRL: begin
            preQ <= wrData[PRE_W-1:0];
            sdQ  <= wrData[SD_BIT];
          end
          OFS_DUTY: begin
            dcQ <= wrData[PV_W-1:0];
            fdQ <= wrData[FD_BIT];
          end
          OFS_PER:  pvQ <= wrData[PV_W-1:0];
          default:  ;
        endcase
      end
    end

    assign sdBits[g] = sdQ;
    assign tim[g]    = '{pre: preQ, dc: dcQ, fd: fdQ, pv: pvQ};
    assign strb[g]   = '{runReq: chEnable[g], killNow: !chEnable[g] && sdQ};
  end

  always_comb begin
    rdData = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (chSel == CH_SEL_W'(ch)) begin
        case (regSel)
          OFS_CTRL: rdData[SD_BIT:0]   = {sdBits[ch], tim[ch].pre};
          OFS_DUTY: rdData[FD_BIT:0]   = {tim[ch].fd, tim[ch].dc};
          OFS_PER:  rdData[PV_W-1:0]   = tim[ch].pv;
          default:  rdData             = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwm_chan_dp.sv
module pwm_chan_dp
  import pwm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  chTime_t   tim,
  input  chStrobe_t strb,
  output logic      pwmOut
);
  chTime_t          act, nAct;
  logic             running, nRun;
  logic [PRE_W-1:0] preCnt, nPre;
  logic [PV_W-1:0]  perCnt, nPer;
  logic             tick, wrap, hiNext;

  assign tick = (preCnt == act.pre);
  assign wrap = tick && (perCnt == act.pv);

  always_comb begin
    nAct = act;
    nRun = running;
    nPre = preCnt;
    nPer = perCnt;
    if (strb.killNow) begin
      nRun = 1'b0;
      nPre = '0;
      nPer = '0;
    end else if (!running) begin
      if (strb.runReq) begin
        nRun = 1'b1;
        nAct = tim;
        nPre = '0;
        nPer = '0;
      end
    end else if (!tick) begin
      nPre = preCnt + 1'b1;
    end else begin
      nPre = '0;
      if (wrap) begin
        nPer = '0;
        nAct = tim;
        nRun = strb.runReq;
      end else begin
        nPer = perCnt + 1'b1;
      end
    end
  end

  assign hiNext = nRun && (nAct.fd || (nPer < nAct.dc));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      act     <= '0;
      running <= 1'b0;
      preCnt  <= '0;
      perCnt  <= '0;
      pwmOut  <= 1'b0;
    end else begin
      act     <= nAct;
      running <= nRun;
      preCnt  <= nPre;
      perCnt  <= nPer;
      pwmOut  <= hiNext;
    end
  end
endmodule

// File: rtl/pwm_dual_ch.sv
module pwm_dual_ch
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [NUM_CH-1:0] chEnable,
  output logic [NUM_CH-1:0] pwmOut
);
  chTime_t   [NUM_CH-1:0] chTim;
  chStrobe_t [NUM_CH-1:0] chStrb;

  pwm_regbank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .chEnable(chEnable), .tim(chTim), .strb(chStrb)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_chan_dp u_dp (
      .clk(clk), .rstN(rstN), .tim(chTim[g]), .strb(chStrb[g]),
      .pwmOut(pwmOut[g])
    );
  end
endmodule

// File: rtl/pwm_dual_ch_chk.sv
module pwm_dual_ch_chk
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   wrEn,
  input logic [ADDR_W-1:0]      addr,
  input logic [DATA_W-1:0]      wrData,
  input logic [NUM_CH-1:0]      chEnable,
  input logic [NUM_CH-1:0]      pwmOut,
  input chTime_t   [NUM_CH-1:0] chTim,
  input chStrobe_t [NUM_CH-1:0] chStrb
);
  logic unusedHi;
  assign unusedHi = ^wrData[DATA_W-1:PV_W];

  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(chTim));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    localparam logic [ADDR_W-1:0] PER_ADDR = ADDR_W'(i * 16 + 8);

    // R1
    wr_period_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == PER_ADDR) |=> chTim[i].pv == $past(wrData[PV_W-1:0]));

    // R8
    kill_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      chStrb[i].killNow |=> !pwmOut[i]);

    // R9
    rise_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pwmOut[i]) |-> $past(chEnable[i]) && $past(chStrb[i].runReq));
  end
endmodule

bind pwm_dual_ch pwm_dual_ch_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .chEnable(chEnable), .pwmOut(pwmOut), .chTim(chTim), .chStrb(chStrb)
);

// File: tb/pwm_dual_ch_tb.sv
module pwm_dual_ch_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [1:0]  chEnable = '0;
  logic [1:0]  pwmOut;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  pwm_dual_ch u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .chEnable(chEnable), .pwmOut(pwmOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic waitRise(input int ch, output bit ok);
    int n = 0;
    while (pwmOut[ch] !== 1'b0 && n < 3000) begin @(negedge clk); n++; end
    while (pwmOut[ch] !== 1'b1 && n < 6000) begin @(negedge clk); n++; end
    ok = (n < 6000);
  endtask

  task automatic measure(input int ch, output int hi, output int per);
    bit ok;
    hi = 0; per = 0;
    waitRise(ch, ok);
    if (!ok) return;
    while (pwmOut[ch] === 1'b1 && per < 3000) begin hi++; per++; @(negedge clk); end
    while (pwmOut[ch] === 1'b0 && per < 3000) begin per++; @(negedge clk); end
  endtask

  task automatic countHigh(input int ch, input int n, output int c);
    c = 0;
    repeat (n) begin @(negedge clk); if (pwmOut[ch] === 1'b1) c++; end
  endtask

  task automatic stopCh(input int ch);
    logic [4:0] base = 5'(ch * 16);
    writeReg(base, 32'h40);
    chEnable[ch] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic setup(input int ch, input int pre, input int duty, input int pv);
    logic [4:0] base = 5'(ch * 16);
    writeReg(base, 32'(pre));
    writeReg(base + 5'd4, 32'(duty));
    writeReg(base + 5'd8, 32'(pv));
  endtask

  task automatic testReset();
    logic [31:0] d;
    logic [4:0] addrs [6] = '{5'h00, 5'h04, 5'h08, 5'h10, 5'h14, 5'h18};
    foreach (addrs[k]) begin
      readReg(addrs[k], d);
      check(d == 0, "R2 register after reset", int'(d), 0);
    end
    check(pwmOut == 2'b00, "R2 outputs after reset", int'(pwmOut), 0);
  endtask

  task automatic testRegMap();
    logic [31:0] d;
    writeReg(5'h00, 32'hFFFF_FFFF);
    writeReg(5'h04, 32'hFFFF_FFFF);
    writeReg(5'h08, 32'hFFFF_FFFF);
    readReg(5'h00, d); check(d == 32'h7F, "R1 control readback", int'(d), 'h7F);
    readReg(5'h04, d); check(d == 32'h7FF, "R1 duty readback", int'(d), 'h7FF);
    readReg(5'h08, d); check(d == 32'h3FF, "R1 period readback", int'(d), 'h3FF);
    writeReg(5'h0C, 32'h1234);
    readReg(5'h0C, d); check(d == 0, "R1 unmapped offset", int'(d), 0);
    writeReg(5'h10, 32'h25);
    writeReg(5'h14, 32'h123);
    writeReg(5'h18, 32'h2AA);
    readReg(5'h10, d); check(d == 32'h25, "R10 ch1 control", int'(d), 'h25);
    readReg(5'h14, d); check(d == 32'h123, "R10 ch1 duty", int'(d), 'h123);
    readReg(5'h18, d); check(d == 32'h2AA, "R10 ch1 period", int'(d), 'h2AA);
    readReg(5'h00, d); check(d == 32'h7F, "R10 ch0 untouched by ch1 writes", int'(d), 'h7F);
    readReg(5'h08, d); check(d == 32'h3FF, "R10 ch0 period untouched", int'(d), 'h3FF);
  endtask

  task automatic testBasic();
    int hi, per;
    setup(0, 0, 3, 9);
    chEnable[0] = 1'b1;
    measure(0, hi, per);
    check(hi == 3, "R4 high time pre0 pv9 dc3", hi, 3);
    check(per == 10, "R3 period pre0 pv9", per, 10);
    stopCh(0);
    setup(0, 2, 2, 4);
    chEnable[0] = 1'b1;
    measure(0, hi, per);
    check(hi == 6, "R4 high time pre2 pv4 dc2", hi, 6);
    check(per == 15, "R3 period pre2 pv4", per, 15);
  endtask

  task automatic testSecond();
    int hi, per;
    setup(1, 1, 5, 7);
    chEnable[1] = 1'b1;
    measure(1, hi, per);
    check(hi == 10, "R10 ch1 high time pre1 pv7 dc5", hi, 10);
    check(per == 16, "R10 ch1 period", per, 16);
    measure(0, hi, per);
    check(hi == 6 && per == 15, "R10 ch0 waveform kept while ch1 runs", hi * 100 + per, 615);
    stopCh(0);
    stopCh(1);
  endtask

  task automatic testExtremes();
    int c;
    setup(0, 0, 32'h400, 5);
    chEnable[0] = 1'b1;
    @(negedge clk);
    countHigh(0, 40, c);
    check(c == 40, "R5 force-high flag with count 0", c, 40);
    stopCh(0);
    setup(0, 0, 0, 5);
    chEnable[0] = 1'b1;
    countHigh(0, 40, c);
    check(c == 0, "R6 zero count gives constant low", c, 0);
    stopCh(0);
    setup(0, 1, 12, 5);
    chEnable[0] = 1'b1;
    @(negedge clk);
    countHigh(0, 40, c);
    check(c == 40, "R6 count above period gives constant high", c, 40);
    stopCh(0);
  endtask

  task automatic testShadow();
    int hi, per, c;
    bit ok;
    setup(0, 0, 3, 9);
    chEnable[0] = 1'b1;
    waitRise(0, ok);
    check(ok, "R7 output started", int'(ok), 1);
    writeReg(5'h04, 32'd7);
    countHigh(0, 4, c);
    check(c == 0, "R7 running period keeps old count", c, 0);
    measure(0, hi, per);
    check(hi == 7, "R7 new count from next period", hi, 7);
    check(per == 10, "R7 period unchanged", per, 10);
    stopCh(0);
  endtask

  task automatic testShutdown();
    int c;
    bit ok;
    setup(0, 32'h40, 8, 9);
    chEnable[0] = 1'b1;
    waitRise(0, ok);
    chEnable[0] = 1'b0;
    @(negedge clk);
    check(pwmOut[0] == 1'b0, "R8 low one cycle after disable", int'(pwmOut[0]), 0);
    countHigh(0, 20, c);
    check(c == 0, "R8 stays low after disable", c, 0);
  endtask

  task automatic testGraceful();
    int h, c;
    bit ok;
    setup(0, 0, 5, 9);
    chEnable[0] = 1'b1;
    waitRise(0, ok);
    chEnable[0] = 1'b0;
    h = 1;
    @(negedge clk);
    while (pwmOut[0] === 1'b1 && h < 100) begin h++; @(negedge clk); end
    check(h == 5, "R9 pulse completes after disable", h, 5);
    countHigh(0, 30, c);
    check(c == 0, "R9 no new period after disable", c, 0);
    stopCh(0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegMap();
    testBasic();
    testSecond();
    testExtremes();
    testShadow();
    testShutdown();
    testGraceful();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule